// File: doc/BRIEF.md
# Four-Group Simple Parallel Port Bank

This block provides ninety-six general purpose digital lines, organised as four identical groups of twenty-four. Each group has two byte-wide ports (A and B) and a third byte-wide port C. Port C is split into an upper and a lower nibble, and each nibble is directed on its own. Software reaches the block through a byte-wide register interface. Each group occupies a window of four consecutive byte addresses: three data registers and one direction control byte.

A port section set as output drives its held value and enables its pad driver. A port section set as input returns the pin level on a read. That level passes through a two-flop synchronizer first. Only the simple, unstrobed operating mode is provided. A control write that lacks the mode flag is discarded. A valid control write reprograms all four section directions of its group and zeroes that group's output latches.

Top module: `pio4_bank`

## Requirements
- R1: After reset every section of every group is an input: all `pin_oe` bits are 0, all `pin_out` bits are 0, and each control register reads 9Bh.
- R2: Group g is reached at byte addresses 4g+0 (port A), 4g+1 (port B), 4g+2 (port C) and 4g+3 (control). Its pins are `pin_*[24g+7:24g]` for A, `[24g+15:24g+8]` for B and `[24g+23:24g+16]` for C.
- R3: A control write with bit 7 set directs the sections from four bits, where 1 means input and 0 means output: bit 4 sets port A, bit 3 sets the upper nibble of C, bit 1 sets port B and bit 0 sets the lower nibble of C. The `pin_oe` bits of each section are 1 exactly when that section is an output.
- R4: A control write with bit 7 clear has no effect on directions, latches or the control readback.
- R5: A control write with bit 7 set clears all three output latches of its group to zero.
- R6: An output section drives the last byte written to its data address on `pin_out`, and a read of that address returns the same value.
- R7: A read of an input section returns the pin level as sampled two clock edges earlier. A change on `pin_in` is not visible after only one edge.
- R8: The two nibbles of port C are handled separately on reads and on `pin_oe`. Bits 3:0 form the lower nibble and bits 7:4 form the upper nibble.
- R9: A read of the control address returns 1 in bit 7, the four direction bits in positions 4, 3, 1 and 0, and 0 in bits 6, 5 and 2.
- R10: Writes to one group leave the directions and latches of every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 4 | Byte address into the register space |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational from register state |
| pin_in | input | 96 | Pin input levels |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enable per pin, 1 when the section is an output |

## Verification
The bench steps through all sixteen direction codes. A design that swaps bit 3 and bit 4, or inverts their sense, drives the wrong pads. It sets the two nibbles of port C in opposite directions. A design that treats port C as one section then returns latch bits where pin bits belong. It samples an input read after one edge and again after two. A design with a missing or extra synchronizer stage returns the new level one cycle early or late. It issues a control write with the mode flag clear, then a valid one. These catch a design that reprograms on any control write, or that fails to clear latches, or that clears them in a neighbouring group.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PORT_W = 8;
  localparam int NIB_W  = PORT_W / 2;
  localparam int GRP_W  = 3 * PORT_W;

  // byte offsets inside a group window
  localparam logic [1:0] OFF_A   = 2'd0;
  localparam logic [1:0] OFF_B   = 2'd1;
  localparam logic [1:0] OFF_C   = 2'd2;
  localparam logic [1:0] OFF_CFG = 2'd3;

  // control byte bit positions
  localparam int CB_MODE = 7;
  localparam int CB_A    = 4;
  localparam int CB_CU   = 3;
  localparam int CB_B    = 1;
  localparam int CB_CL   = 0;

  // direction state, 1 = input
  typedef struct packed {
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } sect_dir_t;

  localparam sect_dir_t DIR_ALL_IN = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_in;
      stg2_q <= stg1_q;
    end
  end

  assign d_sync = stg2_q;
endmodule

// File: rtl/pio_group.sv
module pio_group
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [1:0]        off,
  input  logic              wr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  input  logic [GRP_W-1:0]  pin_in,
  output logic [GRP_W-1:0]  pin_out,
  output logic [GRP_W-1:0]  pin_oe
);
  sect_dir_t         dir_q, dir_d;
  logic [PORT_W-1:0] lat_a_q, lat_a_d;
  logic [PORT_W-1:0] lat_b_q, lat_b_d;
  logic [PORT_W-1:0] lat_c_q, lat_c_d;
  logic [GRP_W-1:0]  pin_s;
  logic              wr_cfg, wr_mode, wr_a, wr_b, wr_c;

  pio_sync #(.WIDTH(GRP_W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (pin_in),
    .d_sync (pin_s)
  );

  assign wr_a    = sel & wr & (off == OFF_A);
  assign wr_b    = sel & wr & (off == OFF_B);
  assign wr_c    = sel & wr & (off == OFF_C);
  assign wr_cfg  = sel & wr & (off == OFF_CFG);
  assign wr_mode = wr_cfg & wdata[CB_MODE];

  always_comb begin
    dir_d   = dir_q;
    lat_a_d = lat_a_q;
    lat_b_d = lat_b_q;
    lat_c_d = lat_c_q;
    if (wr_mode) begin
      dir_d.a_in  = wdata[CB_A];
      dir_d.cu_in = wdata[CB_CU];
      dir_d.b_in  = wdata[CB_B];
      dir_d.cl_in = wdata[CB_CL];
      lat_a_d     = '0;
      lat_b_d     = '0;
      lat_c_d     = '0;
    end else begin
      if (wr_a) lat_a_d = wdata;
      if (wr_b) lat_b_d = wdata;
      if (wr_c) lat_c_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= DIR_ALL_IN;
      lat_a_q <= '0;
      lat_b_q <= '0;
      lat_c_q <= '0;
    end else begin
      dir_q   <= dir_d;
      lat_a_q <= lat_a_d;
      lat_b_q <= lat_b_d;
      lat_c_q <= lat_c_d;
    end
  end

  // pin side
  assign pin_out = {lat_c_q, lat_b_q, lat_a_q};
  assign pin_oe  = { {NIB_W{~dir_q.cu_in}}, {NIB_W{~dir_q.cl_in}},
                     {PORT_W{~dir_q.b_in}}, {PORT_W{~dir_q.a_in}} };

  // read side
  always_comb begin
    unique case (off)
      OFF_A:   rdata = dir_q.a_in ? pin_s[PORT_W-1:0] : lat_a_q;
      OFF_B:   rdata = dir_q.b_in ? pin_s[2*PORT_W-1:PORT_W] : lat_b_q;
      OFF_C:   rdata = { dir_q.cu_in ? pin_s[GRP_W-1:GRP_W-NIB_W] : lat_c_q[PORT_W-1:NIB_W],
                         dir_q.cl_in ? pin_s[2*PORT_W+NIB_W-1:2*PORT_W] : lat_c_q[NIB_W-1:0] };
      default: rdata = {1'b1, 2'b00, dir_q.a_in, dir_q.cu_in, 1'b0, dir_q.b_in, dir_q.cl_in};
    endcase
  end

  // R3: a mode write lands in the direction state on the next edge
  p_cfg_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (dir_q == {$past(wdata[CB_A]), $past(wdata[CB_CU]),
                           $past(wdata[CB_B]), $past(wdata[CB_CL])}));

  // R4: a control write without the mode flag changes nothing
  p_cfg_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !wdata[CB_MODE]) |=> ($stable(dir_q) && $stable(pin_out)));

  // R5: a mode write zeroes every latch of the group
  p_latch_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (pin_out == '0));

  // R6, R10: latches hold while the group is not written
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr) |=> $stable(pin_out) && $stable(dir_q));
endmodule

// File: rtl/pio4_bank.sv
module pio4_bank
  import pio_pkg::*;
#(
  parameter int N_GRP  = 4,
  localparam int GSEL_W = $clog2(N_GRP),
  localparam int ADDR_W = GSEL_W + 2,
  localparam int PINS   = N_GRP * GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  logic [PORT_W-1:0] grp_rdata [N_GRP];
  logic [GSEL_W-1:0] grp_idx;

  assign grp_idx = bus_addr[ADDR_W-1:2];

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    pio_group u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (grp_idx == GSEL_W'(g)),
      .off     (bus_addr[1:0]),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .rdata   (grp_rdata[g]),
      .pin_in  (pin_in[g*GRP_W +: GRP_W]),
      .pin_out (pin_out[g*GRP_W +: GRP_W]),
      .pin_oe  (pin_oe[g*GRP_W +: GRP_W])
    );
  end

  assign bus_rdata = grp_rdata[grp_idx];
endmodule

// File: tb/pio4_bank_tb.sv
module pio4_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [95:0] pin_in, pin_out, pin_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio4_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // R1, R9: reset state
  task automatic t_reset();
    logic [7:0] d;
    chk("R1 oe", pin_oe, '0);
    chk("R1 out", pin_out, '0);
    for (int g = 0; g < 4; g++) begin
      rd_reg(4'(4*g+3), d);
      chk("R1 cfg", {88'd0, d}, {88'd0, 8'h9B});
    end
  endtask

  // R2, R3, R9: all sixteen direction codes on group 1
  task automatic t_codes();
    logic [7:0] code, d;
    logic [23:0] exp_oe;
    for (int i = 0; i < 16; i++) begin
      code = 8'h80 | {3'b000, i[3], i[2], 1'b0, i[1], i[0]};
      wr_reg(4'h7, code);
      exp_oe = { {4{~code[3]}}, {4{~code[0]}}, {8{~code[1]}}, {8{~code[4]}} };
      chk("R3 oe", {72'd0, pin_oe[47:24]}, {72'd0, exp_oe});
      chk("R2 other groups", {pin_oe[95:48], pin_oe[23:0], 24'd0}, '0);
      rd_reg(4'h7, d);
      chk("R9 readback", {88'd0, d}, {88'd0, code});
    end
    wr_reg(4'h7, 8'h9B);
  endtask

  // R6, R10: output latches on group 2
  task automatic t_output();
    logic [7:0] d;
    wr_reg(4'hB, 8'h80);
    wr_reg(4'h8, 8'h5A);
    wr_reg(4'h9, 8'hC3);
    wr_reg(4'hA, 8'h96);
    chk("R6 pins", {72'd0, pin_out[71:48]}, {72'd0, 24'h96C35A});
    chk("R6 oe", {72'd0, pin_oe[71:48]}, {72'd0, 24'hFFFFFF});
    rd_reg(4'h8, d); chk("R6 read A", {88'd0, d}, {88'd0, 8'h5A});
    rd_reg(4'h9, d); chk("R6 read B", {88'd0, d}, {88'd0, 8'hC3});
    rd_reg(4'hA, d); chk("R6 read C", {88'd0, d}, {88'd0, 8'h96});
    chk("R10 neighbours", {pin_out[95:72], pin_out[47:0]}, '0);
  endtask

  // R8: split port C on group 3, upper out, lower in
  task automatic t_cnibble();
    logic [7:0] d;
    wr_reg(4'hF, 8'h81);
    wr_reg(4'hE, 8'hA5);
    @(negedge clk);
    pin_in[91:88] = 4'h3;
    pin_in[95:92] = 4'hC;
    @(negedge clk); @(negedge clk);
    rd_reg(4'hE, d);
    chk("R8 read C", {88'd0, d}, {88'd0, 8'hA3});
    chk("R8 oe C", {88'd0, pin_oe[95:88]}, {88'd0, 8'hF0});
    chk("R8 out C", {88'd0, pin_out[95:88]}, {88'd0, 8'hA5});
  endtask

  // R7: two-stage input sampling on group 0
  task automatic t_sync();
    logic [7:0] d;
    @(negedge clk);
    pin_in[7:0] = 8'h77;
    @(negedge clk);
    rd_reg(4'h0, d);
    chk("R7 one edge", {88'd0, d}, '0);
    @(negedge clk);
    rd_reg(4'h0, d);
    chk("R7 two edges", {88'd0, d}, {88'd0, 8'h77});
  endtask

  // R4: control write without mode flag on group 2
  task automatic t_ignore();
    logic [7:0] d;
    wr_reg(4'hB, 8'h1B);
    rd_reg(4'hB, d);
    chk("R4 cfg", {88'd0, d}, {88'd0, 8'h80});
    chk("R4 oe", {72'd0, pin_oe[71:48]}, {72'd0, 24'hFFFFFF});
    chk("R4 out", {72'd0, pin_out[71:48]}, {72'd0, 24'h96C35A});
  endtask

  // R5, R10: mode write clears latches of its own group only
  task automatic t_clear();
    wr_reg(4'hB, 8'h80);
    chk("R5 cleared", {72'd0, pin_out[71:48]}, '0);
    chk("R10 group3 kept", {88'd0, pin_out[95:88]}, {88'd0, 8'hA5});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_codes();
    t_output();
    t_cnibble();
    t_sync();
    t_ignore();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule